// File: doc/BRIEF.md
# Short-Format Burst Preamble and Header Bit Generator

This block produces, one bit at a time, the serial stream that opens a short-format burst. The stream has four parts: 56 sync bits of zero, a 16-bit start-of-frame marker, 32 bits of header fields, and a 16-bit header check. Every bit leaves through a self-synchronizing scrambler. Each bit carries a rate tag that tells the downstream modulator which mode to use. Preamble bits use 1 Mbps differential BPSK. Header bits use 2 Mbps differential QPSK.

A controller loads the three header fields with a one-cycle `start` pulse. It then sends one `bit_en` pulse per bit period. Each pulse moves the stream on by one bit. The block computes the header check while the header bits go out, so no second pass over the fields is needed. When the last check bit appears, `hdr_done` pulses. The payload source then takes over and continues from the scrambler state that the block exposes.

Top module: `hdr_burst_gen`

## Requirements
- R1: After reset, `bit_out`, `rate_tag` and `hdr_done` are 0 and `scr_state` holds the seed 7'b0011011.
- R2: A `start` pulse while idle latches `sig_fld`, `svc_fld` and `len_fld`, reloads the scrambler with 7'b0011011 and sets the check register to all ones. A `start` pulse during a burst has no effect on the stream.
- R3: Each `bit_en` pulse during a burst emits the next of 120 bits. The bit appears on `bit_out` one clock later and holds until the next `bit_en`. A `bit_en` pulse while idle changes no output.
- R4: The transmitted bit equals raw ^ s[3] ^ s[6], where s[0] is the newest bit in the register. The transmitted bit is then shifted into s[0].
- R5: Raw bits 0 to 55 are zero.
- R6: Raw bits 56 to 71 are the marker 16'h05CF, bit 0 of the marker first.
- R7: Raw bits 72 to 103 are `sig_fld`, then `svc_fld`, then `len_fld`, each sent least significant bit first.
- R8: The check uses x^16+x^12+x^5+1, starts at 16'hFFFF and runs over the 32 raw field bits. It is sent ones-complemented, most significant bit first, as raw bits 104 to 119.
- R9: `rate_tag` is 0 (1 Mbps DBPSK) for bits 0 to 71 and 1 (2 Mbps DQPSK) for bits 72 to 119.
- R10: `hdr_done` is high for exactly one clock, on the clock in which bit 119 first appears on `bit_out`.
- R11: After the burst, `scr_state` holds the last seven transmitted bits, newest in bit 0. This value stays unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst and latch the header fields |
| bit_en | input | 1 | One pulse per bit period |
| sig_fld | input | 8 | Signal field |
| svc_fld | input | 8 | Service field |
| len_fld | input | 16 | Length field |
| bit_out | output | 1 | Scrambled serial bit |
| rate_tag | output | 1 | 0 = 1 Mbps DBPSK, 1 = 2 Mbps DQPSK |
| hdr_done | output | 1 | One-clock pulse with the last check bit |
| scr_state | output | 7 | Scrambler register, handed to the payload source |

## Verification
Each emitted bit, its rate tag and the done flag are registered on the same clock edge that samples `bit_en`. They are therefore due one cycle after the pulse. The bench raises `bit_en` for one cycle and reads the outputs at the following falling edge, before the next pulse is issued. It checks `hdr_done` again one cycle later to confirm the pulse lasts a single clock. A `start` is accepted at one edge, and the first `bit_en` is issued no earlier than the next cycle. The scrambler handoff value is read after the final bit and again after several idle `bit_en` pulses.

// File: rtl/hdr_gen_pkg.sv
package hdr_gen_pkg;
  localparam int SYNC_BITS  = 56;
  localparam int SFD_BITS   = 16;
  localparam int FLD_BITS   = 32;
  localparam int CHK_BITS   = 16;
  localparam int SCR_BITS   = 7;
  localparam int TOTAL_BITS = SYNC_BITS + SFD_BITS + FLD_BITS + CHK_BITS;

  localparam logic [SFD_BITS-1:0] SFD_PATTERN = 16'h05CF;
  localparam logic [CHK_BITS-1:0] CHK_POLY    = 16'h1021;
  localparam logic [SCR_BITS-1:0] SCR_SEED    = 7'b0011011;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SFD  = 2'd1,
    PH_FLD  = 2'd2,
    PH_CHK  = 2'd3
  } phase_t;
endpackage

// File: rtl/hdr_scrambler.sv
module hdr_scrambler #(
  parameter int                  W     = 7,
  parameter int                  TAP_A = 3,
  parameter int                  TAP_B = 6,
  parameter logic [W-1:0]        SEED  = 7'b0011011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic         din,
  output logic         dout,
  output logic [W-1:0] state
);
  logic [W-1:0] s_q;

  assign dout  = din ^ s_q[TAP_A] ^ s_q[TAP_B];
  assign state = s_q;

  always_ff @(posedge clk) begin
    if (rst)       s_q <= SEED;
    else if (load) s_q <= SEED;
    else if (adv)  s_q <= {s_q[W-2:0], dout};
  end
endmodule

// File: rtl/hdr_crc16.sv
module hdr_crc16 #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic tx_bit
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb     = crc_q[W-1] ^ din;
  assign tx_bit = ~crc_q[W-1];

  always_ff @(posedge clk) begin
    if (rst)        crc_q <= '1;
    else if (init)  crc_q <= '1;
    else if (upd)   crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    else if (shift) crc_q <= {crc_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/hdr_seq.sv
module hdr_seq
  import hdr_gen_pkg::*;
#(
  parameter int SYNC_N = SYNC_BITS,
  parameter int SFD_N  = SFD_BITS,
  parameter int FLD_N  = FLD_BITS,
  parameter int CHK_N  = CHK_BITS,
  parameter logic [SFD_N-1:0] SFD_PAT = SFD_PATTERN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_en,
  input  logic [FLD_N-1:0] fields,
  output logic             busy,
  output logic             accept,
  output logic             adv,
  output logic             last,
  output phase_t           phase,
  output logic             raw_bit
);
  localparam int TOT   = SYNC_N + SFD_N + FLD_N + CHK_N;
  localparam int IDXW  = $clog2(TOT);
  localparam int SFDW  = $clog2(SFD_N);
  localparam int FLDW  = $clog2(FLD_N);
  localparam int B_SFD = SYNC_N;
  localparam int B_FLD = SYNC_N + SFD_N;
  localparam int B_CHK = SYNC_N + SFD_N + FLD_N;

  logic [IDXW-1:0]  idx_q;
  logic [FLD_N-1:0] fld_q;
  logic             busy_q;
  logic [IDXW-1:0]  off_sfd;
  logic [IDXW-1:0]  off_fld;

  assign busy    = busy_q;
  assign accept  = start && !busy_q;
  assign adv     = bit_en && busy_q;
  assign last    = (idx_q == IDXW'(TOT - 1));
  assign off_sfd = idx_q - IDXW'(B_SFD);
  assign off_fld = idx_q - IDXW'(B_FLD);

  always_comb begin
    if (idx_q < IDXW'(B_SFD))      phase = PH_SYNC;
    else if (idx_q < IDXW'(B_FLD)) phase = PH_SFD;
    else if (idx_q < IDXW'(B_CHK)) phase = PH_FLD;
    else                           phase = PH_CHK;
  end

  always_comb begin
    case (phase)
      PH_SFD:  raw_bit = SFD_PAT[off_sfd[SFDW-1:0]];
      PH_FLD:  raw_bit = fld_q[off_fld[FLDW-1:0]];
      default: raw_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      fld_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      fld_q  <= fields;
    end else if (adv) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdr_burst_gen.sv
module hdr_burst_gen
  import hdr_gen_pkg::*;
#(
  parameter int SIG_W = 8,
  parameter int SVC_W = 8,
  parameter int LEN_W = 16,
  parameter int SCR_W = SCR_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_en,
  input  logic [SIG_W-1:0] sig_fld,
  input  logic [SVC_W-1:0] svc_fld,
  input  logic [LEN_W-1:0] len_fld,
  output logic             bit_out,
  output logic             rate_tag,
  output logic             hdr_done,
  output logic [SCR_W-1:0] scr_state
);
  localparam int FLD_W = SIG_W + SVC_W + LEN_W;

  logic   busy, accept, adv, last, seq_raw, chk_bit, raw, scr_bit;
  phase_t phase;

  hdr_seq #(
    .SYNC_N (SYNC_BITS),
    .SFD_N  (SFD_BITS),
    .FLD_N  (FLD_W),
    .CHK_N  (CHK_BITS),
    .SFD_PAT(SFD_PATTERN)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .bit_en (bit_en),
    .fields ({len_fld, svc_fld, sig_fld}),
    .busy   (busy),
    .accept (accept),
    .adv    (adv),
    .last   (last),
    .phase  (phase),
    .raw_bit(seq_raw)
  );

  hdr_crc16 #(
    .W   (CHK_BITS),
    .POLY(CHK_POLY)
  ) u_crc (
    .clk   (clk),
    .rst   (rst),
    .init  (accept),
    .upd   (adv && phase == PH_FLD),
    .shift (adv && phase == PH_CHK),
    .din   (seq_raw),
    .tx_bit(chk_bit)
  );

  assign raw = (phase == PH_CHK) ? chk_bit : seq_raw;

  hdr_scrambler #(
    .W    (SCR_W),
    .TAP_A(3),
    .TAP_B(6),
    .SEED (SCR_SEED)
  ) u_scr (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .adv  (adv),
    .din  (raw),
    .dout (scr_bit),
    .state(scr_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out  <= 1'b0;
      rate_tag <= 1'b0;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= adv && last;
      if (adv) begin
        bit_out  <= scr_bit;
        rate_tag <= (phase == PH_FLD) || (phase == PH_CHK);
      end
    end
  end
endmodule

// File: rtl/hdr_gen_chk.sv
module hdr_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       bit_en,
  input logic       busy,
  input logic       bit_out,
  input logic       rate_tag,
  input logic       hdr_done,
  input logic [6:0] scr_state
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> !hdr_done);

  a_r10_done_after_en: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> $past(bit_en));

  a_r3_hold_without_en: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(bit_out) && $stable(rate_tag)));

  a_r4_scr_shift: assert property (@(posedge clk) disable iff (rst)
    (bit_en && busy) |=> (scr_state[0] == bit_out &&
                          scr_state[6:1] == $past(scr_state[5:0])));

  a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (scr_state == 7'b0011011));

  a_r9_rate_rise_on_en: assert property (@(posedge clk) disable iff (rst)
    $rose(rate_tag) |-> $past(bit_en));

  a_r11_state_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(scr_state));
endmodule

bind hdr_burst_gen hdr_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .bit_en   (bit_en),
  .busy     (busy),
  .bit_out  (bit_out),
  .rate_tag (rate_tag),
  .hdr_done (hdr_done),
  .scr_state(scr_state)
);

// File: tb/sim_hdr_burst_gen.sv
module sim_hdr_burst_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bit_en = 1'b0;
  logic [7:0]  sig_fld = '0;
  logic [7:0]  svc_fld = '0;
  logic [15:0] len_fld = '0;
  logic        bit_out, rate_tag, hdr_done;
  logic [6:0]  scr_state;

  int n_chk = 0;
  int n_bad = 0;

  logic [119:0] exp_bits;
  logic [6:0]   exp_scr;

  always #2 clk = ~clk;

  hdr_burst_gen u0 (
    .clk(clk), .rst(rst), .start(start), .bit_en(bit_en),
    .sig_fld(sig_fld), .svc_fld(svc_fld), .len_fld(len_fld),
    .bit_out(bit_out), .rate_tag(rate_tag), .hdr_done(hdr_done),
    .scr_state(scr_state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference stream built from R4 to R8
  task automatic build_model(input logic [7:0] sg, input logic [7:0] sv, input logic [15:0] ln);
    logic [119:0] raw;
    logic [31:0]  f;
    logic [15:0]  c;
    logic [6:0]   s;
    logic         fb, o;
    raw = '0;
    for (int k = 0; k < 16; k++) raw[56+k] = 16'h05CF >> k & 16'h1;
    f = {ln, sv, sg};
    c = 16'hFFFF;
    for (int k = 0; k < 32; k++) begin
      raw[72+k] = f[k];
      fb = c[15] ^ f[k];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    for (int k = 0; k < 16; k++) raw[104+k] = ~c[15-k];
    s = 7'b0011011;
    for (int k = 0; k < 120; k++) begin
      o = raw[k] ^ s[3] ^ s[6];
      exp_bits[k] = o;
      s = {s[5:0], o};
    end
    exp_scr = s;
  endtask

  task automatic pulse_start(input logic [7:0] sg, input logic [7:0] sv, input logic [15:0] ln);
    @(negedge clk);
    sig_fld = sg; svc_fld = sv; len_fld = ln; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic one_bit(input int i);
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    check(bit_out === exp_bits[i], $sformatf("R3/R4/R5/R6/R7/R8 bit %0d", i), bit_out, exp_bits[i]);
    check(rate_tag === (i >= 72), $sformatf("R9 rate bit %0d", i), rate_tag, (i >= 72));
    check(hdr_done === (i == 119), $sformatf("R10 done bit %0d", i), hdr_done, (i == 119));
  endtask

  task automatic test_reset;
    check(bit_out === 1'b0, "R1 bit_out", bit_out, 0);
    check(rate_tag === 1'b0, "R1 rate_tag", rate_tag, 0);
    check(hdr_done === 1'b0, "R1 hdr_done", hdr_done, 0);
    check(scr_state === 7'b0011011, "R1 scr_state", scr_state, 7'b0011011);
  endtask

  task automatic test_burst(input logic [7:0] sg, input logic [7:0] sv, input logic [15:0] ln);
    build_model(sg, sv, ln);
    pulse_start(sg, sv, ln);
    check(scr_state === 7'b0011011, "R2 seed reload", scr_state, 7'b0011011);
    for (int i = 0; i < 120; i++) one_bit(i);
    @(negedge clk);
    check(hdr_done === 1'b0, "R10 done width", hdr_done, 0);
    check(scr_state === exp_scr, "R11 handoff state", scr_state, exp_scr);
  endtask

  task automatic test_start_ignored;
    build_model(8'h0A, 8'h04, 16'h0123);
    pulse_start(8'h0A, 8'h04, 16'h0123);
    for (int i = 0; i < 80; i++) one_bit(i);
    pulse_start(8'h6E, 8'hFF, 16'hBEEF);  // R2: ignored mid-burst
    for (int i = 80; i < 120; i++) one_bit(i);
    @(negedge clk);
    check(scr_state === exp_scr, "R2 start ignored state", scr_state, exp_scr);
  endtask

  task automatic test_idle_en;
    logic       b0;
    logic [6:0] s0;
    b0 = bit_out; s0 = scr_state;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) bit_en = 1'b1;
      @(negedge clk) bit_en = 1'b0;
      check(bit_out === b0 && hdr_done === 1'b0, "R3 idle bit_en ignored", bit_out, b0);
      check(scr_state === s0, "R11 state stable idle", scr_state, s0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_burst(8'h0A, 8'h00, 16'h0040);
    test_idle_en();
    test_burst(8'hFF, 8'hFF, 16'hFFFF);
    test_burst(8'h00, 8'h00, 16'h0000);
    test_burst(8'h6E, 8'h84, 16'hA5C3);
    test_start_ignored();
    test_idle_en();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule